// File: doc/BRIEF.md
# Dual-Input Page Program Receiver

This block is the slave-side front end of a serial flash that accepts one command: a page program in which the data travels over two wires. While chip select is low, the first 32 rising edges of the serial clock carry an 8-bit command code and then a 24-bit start address, both most significant bit first on the primary data pin. After that, every rising edge carries two data bits at once: the secondary pin, which is normally the flash's output, delivers the odd-numbered bit and the primary pin delivers the even-numbered bit. The highest pair comes first, so four edges complete one byte.

Each completed byte is offered on a valid/ready write-request port together with its target address. The low eight address bits then advance and wrap inside a 256-byte page. If chip select rises while the header is only partly received, or partway through a byte, the partial content is dropped and a one-cycle abort pulse is raised. An unknown command code makes the block stay silent until chip select is released. The secondary pin's output enable is never asserted.

The serial pins are brought into the system clock domain through synchronizers, and serial clock edges are found by oversampling. The write port cannot stall the serial bus. Back-pressure therefore works as follows: a request stays presented and unchanged until it is accepted. If a newer byte completes before that, the newer byte replaces the older one, and the older one is lost.

Top module: `dspp_rx_top`

## Requirements
- R1: After reset, wr_valid and abort are 0 and sio1_oe is 0.
- R2: The command code 8'hA2 is taken MSB first from sio0 on the first 8 rising sck edges after cs_n falls; only that code opens the address phase.
- R3: Rising sck edges 9 to 32 carry address bits 23 down to 0 on sio0, MSB first; sio1 is ignored during these 32 edges. The first byte's request carries exactly this address.
- R4: In the data phase, each byte takes 4 rising edges. Each edge supplies the bit pair {sio1, sio0}, in the order bits 7:6, 5:4, 3:2 and 1:0.
- R5: Each completed byte makes one write request. Address bits 7:0 then increase by one and wrap from 8'hFF to 8'h00, while bits 23:8 stay the same.
- R6: Any number of bytes may follow the address, each producing exactly one request. Every new chip-select-low period starts again at the command code.
- R7: With any command code other than 8'hA2, the block makes no write request and no abort pulse until cs_n goes high. The next transaction is decoded normally.
- R8: If cs_n rises after 1 to 31 header edges, or after 1 to 3 edges of a byte, abort pulses high for exactly one clock and the partial byte makes no request.
- R9: If cs_n rises on a byte boundary, including right after the 32nd edge, no abort pulse occurs.
- R10: While wr_valid is 1 and wr_ready is 0, wr_addr and wr_data hold. After acceptance, wr_valid drops unless a new byte is loaded. A byte that completes while another is pending replaces it.
- R11: sio1_oe stays 0 at all times, so the secondary pin stays high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, sampled on its rising edge |
| sio0 | input | 1 | Primary serial data pin (header bits, even data bits) |
| sio1_in | input | 1 | Input side of the secondary pin (odd data bits) |
| sio1_oe | output | 1 | Output enable of the secondary pin, always 0 |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted by the downstream side |
| wr_addr | output | 24 | Target byte address of the request |
| wr_data | output | 8 | Byte to be written |
| abort | output | 1 | One-cycle pulse on an incomplete transfer |

## Verification
The assertions assume that sck stays high and low for longer than the synchronizer depth plus one system clock. They also assume that cs_n never changes in the same system clock as an sck edge, and that sck is low whenever cs_n moves. Under these assumptions every serial edge is seen once and abort can only be a single-cycle pulse. The stimulus holds each sck level for four system clocks. It changes data pins and chip select only while sck is low, with several idle clocks on both sides of each chip-select edge. It exercises wrong codes, aborts in every phase, a page wrap and a stalled write port.

// File: rtl/dspp_rx_pkg.sv
package dspp_rx_pkg;
  localparam int OP_W   = 8;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;
  localparam logic [OP_W-1:0] PROG_CODE = 8'hA2;

  typedef enum logic [1:0] {
    PH_HDR,
    PH_DATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/dspp_sync.sv
module dspp_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dspp_decoder.sv
module dspp_decoder
  import dspp_rx_pkg::*;
#(
  parameter int OPW   = OP_W,
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  parameter int PAGE_BITS = 8,
  parameter logic [OPW-1:0] CODE = PROG_CODE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sck_s,
  input  logic          d0_s,
  input  logic          d1_s,
  output logic          emit,
  output logic [AW-1:0] emit_addr,
  output logic [DW-1:0] emit_data,
  output logic          abort
);
  localparam int HDR_BITS = OPW + AW;
  localparam int HCW      = $clog2(HDR_BITS);
  localparam int PAIRS    = DW / 2;
  localparam int PCW      = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  phase_e                phase;
  logic [HCW-1:0]        hcnt;
  logic [PCW-1:0]        pcnt;
  logic [HDR_BITS-2:0]   hsr;
  logic [DW-3:0]         bsr;
  logic [AW-1:0]         cur_addr;
  logic                  sck_q, cs_q;
  logic                  rise, cs_rise, abort_c, last_pair;
  logic [HDR_BITS-1:0]   hdr_next;
  logic [DW-1:0]         byte_next;
  logic [PAGE_BITS-1:0]  lo_inc;

  assign rise      = sck_s & ~sck_q & ~cs_s;
  assign cs_rise   = cs_s & ~cs_q;
  assign hdr_next  = {hsr, d0_s};
  assign byte_next = {bsr, d1_s, d0_s};
  assign last_pair = (pcnt == PCW'(PAIRS - 1));
  assign lo_inc    = cur_addr[PAGE_BITS-1:0] + PAGE_BITS'(1);
  assign abort_c   = cs_rise &&
                     ((phase == PH_HDR && hcnt != '0) ||
                      (phase == PH_DATA && pcnt != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      abort <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
      abort <= abort_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_HDR;
      hcnt      <= '0;
      pcnt      <= '0;
      hsr       <= '0;
      bsr       <= '0;
      cur_addr  <= '0;
      emit      <= 1'b0;
      emit_addr <= '0;
      emit_data <= '0;
    end else begin
      emit <= 1'b0;
      if (cs_s) begin
        phase <= PH_HDR;
        hcnt  <= '0;
        pcnt  <= '0;
      end else if (rise) begin
        unique case (phase)
          PH_HDR: begin
            hsr  <= hdr_next[HDR_BITS-2:0];
            hcnt <= hcnt + HCW'(1);
            if (hcnt == HCW'(OPW - 1) && hdr_next[OPW-1:0] != CODE)
              phase <= PH_SKIP;
            if (hcnt == HCW'(HDR_BITS - 1)) begin
              cur_addr <= hdr_next[AW-1:0];
              phase    <= PH_DATA;
              pcnt     <= '0;
            end
          end
          PH_DATA: begin
            bsr  <= byte_next[DW-3:0];
            pcnt <= last_pair ? '0 : pcnt + PCW'(1);
            if (last_pair) begin
              emit      <= 1'b1;
              emit_addr <= cur_addr;
              emit_data <= byte_next;
              cur_addr  <= {cur_addr[AW-1:PAGE_BITS], lo_inc};
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r8_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);
  a_r7_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> (!emit && !abort_c));
  a_r5_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (cur_addr[PAGE_BITS-1:0] == emit_addr[PAGE_BITS-1:0] + PAGE_BITS'(1)) &&
             (cur_addr[AW-1:PAGE_BITS] == emit_addr[AW-1:PAGE_BITS]));
  a_r9_no_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && cs_s) |=> !abort);
endmodule

// File: rtl/dspp_wr_hold.sv
module dspp_wr_hold #(
  parameter int AW = 24,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= ld_addr;
      data  <= ld_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(addr) && $stable(data)));
  a_r10_rise_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(load));
  a_r10_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> !valid);
endmodule

// File: rtl/dspp_rx_top.sv
module dspp_rx_top
  import dspp_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_BITS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sio0,
  input  logic              sio1_in,
  output logic              sio1_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              abort
);
  logic [3:0]        pins_s;
  logic              emit;
  logic [ADDR_W-1:0] emit_addr;
  logic [DATA_W-1:0] emit_data;

  // secondary pin is an input for the whole command
  assign sio1_oe = 1'b0;

  dspp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sck, sio1_in, sio0}),
    .q     (pins_s)
  );

  dspp_decoder #(
    .OPW(OP_W), .AW(ADDR_W), .DW(DATA_W),
    .PAGE_BITS(PAGE_BITS), .CODE(PROG_CODE)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (pins_s[3]),
    .sck_s     (pins_s[2]),
    .d1_s      (pins_s[1]),
    .d0_s      (pins_s[0]),
    .emit      (emit),
    .emit_addr (emit_addr),
    .emit_data (emit_data),
    .abort     (abort)
  );

  dspp_wr_hold #(.AW(ADDR_W), .DW(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (emit),
    .ld_addr (emit_addr),
    .ld_data (emit_data),
    .ready   (wr_ready),
    .valid   (wr_valid),
    .addr    (wr_addr),
    .data    (wr_data)
  );

  a_r11_pin_input: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !sio1_oe);
endmodule

// File: tb/tb_dspp_rx_top.sv
module tb_dspp_rx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, sio0 = 1'b0, sio1_in = 1'b0;
  logic        wr_ready = 1'b1;
  logic        sio1_oe, wr_valid, abort;
  logic [23:0] wr_addr;
  logic [7:0]  wr_data;

  int checks = 0, errors = 0, aborts_seen = 0, aborts_exp = 0;
  logic [23:0] qa[$];
  logic [7:0]  qd[$];

  always #2.5 clk = ~clk;

  dspp_rx_top dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sio0(sio0),
    .sio1_in(sio1_in), .sio1_oe(sio1_oe), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .abort(abort)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference side: every accepted request must match the queue front
  always @(negedge clk) begin
    if (rst_n) begin
      if (abort) aborts_seen++;
      if (wr_valid && wr_ready) begin
        if (qa.size() == 0) begin
          check(1'b0, "R6 unexpected request", int'(wr_addr), 0);
        end else begin
          check(wr_addr == qa[0], "R3/R5 address", int'(wr_addr), int'(qa[0]));
          check(wr_data == qd[0], "R4 data", int'(wr_data), int'(qd[0]));
          void'(qa.pop_front());
          void'(qd.pop_front());
        end
      end
    end
  end

  task automatic sclk(input logic b0, input logic b1);
    @(negedge clk);
    sio0 = b0; sio1_in = b1;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic cs_low();
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int npairs);
    for (int p = 0; p < npairs; p++)
      sclk(b[6-2*p], b[7-2*p]);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [23:0] a, input int nbits);
    logic [31:0] h;
    h = {op, a};
    for (int i = 0; i < nbits; i++) sclk(h[31-i], ~h[31-i]);
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed + i * 53);
  endfunction

  task automatic txn(input logic [7:0] op, input logic [23:0] a, input int hbits,
                     input int nbytes, input int tail, input int seed,
                     input bit exp_abort, input string req);
    cs_low();
    send_hdr(op, a, hbits);
    if (hbits == 32) begin
      for (int b = 0; b < nbytes; b++) begin
        if (op == 8'hA2) begin
          qa.push_back({a[23:8], 8'(a[7:0] + b)});
          qd.push_back(pat(seed, b));
        end
        send_byte(pat(seed, b), 4);
      end
      if (tail > 0) send_byte(8'h5A, tail);
    end
    cs_high();
    if (exp_abort) aborts_exp++;
    check(aborts_seen == aborts_exp, {req, " abort count"}, aborts_seen, aborts_exp);
    check(qa.size() == 0, {req, " requests drained"}, qa.size(), 0);
    check(sio1_oe == 1'b0, "R11 oe", int'(sio1_oe), 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wr_valid == 1'b0, "R1 valid", int'(wr_valid), 0);
    check(abort == 1'b0, "R1 abort", int'(abort), 0);
    check(sio1_oe == 1'b0, "R1 oe", int'(sio1_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    txn(8'hA2, 24'h123456, 32, 3, 0, 7, 1'b0, "R2 R3 R4 basic");
    txn(8'hA2, 24'hABCDFE, 32, 4, 0, 200, 1'b0, "R5 page wrap");
    txn(8'hA2, 24'h000010, 32, 0, 0, 0, 1'b0, "R9 no data");
    txn(8'h03, 24'h001000, 32, 3, 0, 9, 1'b0, "R7 wrong code");
    txn(8'h0B, 24'h001000, 12, 0, 0, 0, 1'b0, "R7 wrong code cut");
    txn(8'hA2, 24'h00FF00, 3, 0, 0, 0, 1'b1, "R8 opcode cut");
    txn(8'hA2, 24'h00FF00, 20, 0, 0, 0, 1'b1, "R8 address cut");
    txn(8'hA2, 24'h777770, 32, 2, 2, 33, 1'b1, "R8 byte cut");
    txn(8'hA2, 24'h4000F8, 32, 20, 0, 91, 1'b0, "R6 long burst");

    // R10: stalled port, second byte replaces first
    wr_ready = 1'b0;
    cs_low();
    send_hdr(8'hA2, 24'h010203, 32);
    send_byte(8'h11, 4);
    repeat (6) @(negedge clk);
    check(wr_valid && wr_data == 8'h11, "R10 held first", int'(wr_data), 8'h11);
    send_byte(8'h22, 4);
    cs_high();
    check(wr_valid == 1'b1, "R10 still valid", int'(wr_valid), 1);
    check(wr_data == 8'h22, "R10 replaced data", int'(wr_data), 8'h22);
    check(wr_addr == 24'h010204, "R10 replaced addr", int'(wr_addr), 24'h010204);
    repeat (5) @(negedge clk);
    check(wr_data == 8'h22, "R10 stable", int'(wr_data), 8'h22);
    qa.push_back(24'h010204);
    qd.push_back(8'h22);
    wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(wr_valid == 1'b0, "R10 dropped", int'(wr_valid), 0);
    check(qa.size() == 0, "R10 accepted", qa.size(), 0);

    txn(8'hA2, 24'hFEDCBA, 32, 2, 0, 5, 1'b0, "R6 restart");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule